// File: doc/BRIEF.md
# Dithered-Edge Square Wave Synthesizer

This block produces a square wave for a 14-bit DAC from a 32-bit phase accumulator. A tuning word sets the rate. When the output period is not a whole number of clocks, the accumulator edge lands one clock early or late from period to period. On an analog screen the waveform then shows two edges, one clock apart.

To soften that double edge, a tick counter measures the clocks since the most recent accumulator wrap. Two programmable tick positions mark the clock where a rising edge is uncertain and the clock where a falling edge is uncertain. At those clocks the DAC receives a pseudo-random code in the upper or lower middle of its range instead of a full-scale rail. Over many periods the doubled edges blend into one.

The tick positions are computed elsewhere. For a 200 MHz clock and a 3 MHz output they are 33 and 65.

Top module: `sqdither_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the design resets: `dac_code` becomes 0, the phase and the tick count become 0, and the random generator is loaded with 11'h001.
- R2: On every enabled clock the phase register adds `ftw` modulo 2^32. The raw square level is bit 31 of the phase register.
- R3: On an enabled clock where the addition carries out of bit 31, the tick count becomes 0. On any other enabled clock it increments by one.
- R4: On a tick that is neither marked position, the output is 14'h3FFF when the raw level is high and 14'h0000 when it is low.
- R5: On a tick equal to `rise_tick` with the raw level high, the output is {3'b101, rnd} (10240 + rnd).
- R6: On a tick equal to `rise_tick` with the raw level low, the output is {3'b010, rnd} (4096 + rnd).
- R7: On a tick equal to `fall_tick` with the raw level low, the output is {3'b010, rnd}.
- R8: On a tick equal to `fall_tick` with the raw level high, the output is {3'b101, rnd}.
- R9: When `rise_tick` equals `fall_tick`, the rising-edge rule applies.
- R10: `rnd` is an 11-bit shift register. It steps on every clock, whether enabled or not, as q <= {q[9:0], q[10]^q[8]}. It never holds zero.
- R11: `dac_code` is registered. It reflects the phase, tick and `rnd` values held before the clock edge that loads it.
- R12: When `en` is low, `dac_code` becomes 0 and the phase and tick count hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable |
| ftw | input | 32 | Frequency tuning word |
| rise_tick | input | 16 | Tick position of the uncertain rising edge |
| fall_tick | input | 16 | Tick position of the uncertain falling edge |
| dac_code | output | 14 | Registered DAC code |

## Verification
Some rules are checked by assertions on every clock:
- the never-zero rule for the random register;
- the clear-or-increment rule for the tick counter;
- phase hold while disabled;
- full-scale rails on unmarked ticks;
- the mid-level code prefixes on marked ticks;
- rising-edge priority when the two marks coincide.

Other behaviour shows up only in the bench scenarios:
- the exact random values and one-clock latency;
- the agreement between the accumulator MSB and the chosen prefix;
- resumption of the phase after a disabled interval;
- the reference 3 MHz case over many periods.

// File: rtl/sqd_pkg.sv
// Package: shared types and constants for the dithered square generator.
// Assumes a DAC word three bits wider than the random value.
package sqd_pkg;

    // Which kind of clock tick is being processed
    typedef enum logic [1:0] {
        MARK_LEVEL = 2'd0,
        MARK_RISE  = 2'd1,
        MARK_FALL  = 2'd2
    } mark_e;

    localparam logic [2:0] PREFIX_UPPER = 3'b101;
    localparam logic [2:0] PREFIX_LOWER = 3'b010;

endpackage

// File: rtl/sqd_phase_acc.sv
// Phase accumulator: adds the tuning word on each enabled clock.
// Presents the combinational carry of the pending add so that a
// neighbour can clear on the same edge. Holds while disabled.
module sqd_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] ftw,
    output logic [ACC_W-1:0] phase_q,
    output logic             wrap
);

    logic [ACC_W:0] sum;

    // Pending sum including carry out of the top bit
    always_comb begin
        sum  = {1'b0, phase_q} + {1'b0, ftw};
        wrap = en & sum[ACC_W];
    end

    // Phase register update
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (en)
            phase_q <= sum[ACC_W-1:0];
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(phase_q)); // R12

endmodule

// File: rtl/sqd_tick_ctr.sv
// Tick counter: counts enabled clocks since the last accumulator wrap.
// Assumes clr is valid only together with en.
module sqd_tick_ctr #(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    output logic [TICK_W-1:0] tick_q
);

    // Clear on wrap, otherwise step
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_q <= '0;
        else if (en)
            tick_q <= clr ? '0 : tick_q + TICK_W'(1);
    end

    AST_TICK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr) |=> (tick_q == '0)); // R3
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (tick_q == $past(tick_q) + TICK_W'(1))); // R3
    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(tick_q)); // R12

endmodule

// File: rtl/sqd_lfsr.sv
// Fibonacci shift register that steps every clock.
// TAP_HI and TAP_LO are the bit indices XORed into the new LSB.
// The seed must be nonzero; with a maximal polynomial the zero state
// is unreachable.
module sqd_lfsr #(
    parameter int          W      = 11,
    parameter int          TAP_HI = 10,
    parameter int          TAP_LO = 8,
    parameter logic [W-1:0] SEED  = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] rnd_q
);

    logic fb;

    // Feedback bit from the two taps
    always_comb fb = rnd_q[TAP_HI] ^ rnd_q[TAP_LO];

    // Shift left, insert feedback
    always_ff @(posedge clk) begin
        if (!rst_n)
            rnd_q <= SEED;
        else
            rnd_q <= {rnd_q[W-2:0], fb};
    end

    AST_RND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_q != '0); // R10

endmodule

// File: rtl/sqdither_gen.sv
// Dithered-edge square synthesizer top. It classifies each tick as
// level, rising mark or falling mark. At a mark it drives a random
// mid-level code; elsewhere it drives a full-scale rail. The output
// is registered. Assumes DAC_W = random width + 3.
module sqdither_gen #(
    parameter int ACC_W  = 32,
    parameter int TICK_W = 16,
    parameter int DAC_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ACC_W-1:0]  ftw,
    input  logic [TICK_W-1:0] rise_tick,
    input  logic [TICK_W-1:0] fall_tick,
    output logic [DAC_W-1:0]  dac_code
);
    import sqd_pkg::*;

    localparam int RND_W = DAC_W - 3;

    logic [ACC_W-1:0]  phase_q;
    logic              wrap;
    logic [TICK_W-1:0] tick_q;
    logic [RND_W-1:0]  rnd_q;
    logic              raw_sq;
    mark_e             mark;
    logic [DAC_W-1:0]  dac_next;

    sqd_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .en(en), .ftw(ftw),
        .phase_q(phase_q), .wrap(wrap)
    );

    sqd_tick_ctr #(.TICK_W(TICK_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(wrap), .tick_q(tick_q)
    );

    sqd_lfsr #(.W(RND_W), .TAP_HI(RND_W-1), .TAP_LO(RND_W-3),
               .SEED(RND_W'(1))) u_rnd (
        .clk(clk), .rst_n(rst_n), .rnd_q(rnd_q)
    );

    // Raw square is the phase MSB
    always_comb raw_sq = phase_q[ACC_W-1];

    // Tick classification, rising mark first
    always_comb begin
        if (tick_q == rise_tick)
            mark = MARK_RISE;
        else if (tick_q == fall_tick)
            mark = MARK_FALL;
        else
            mark = MARK_LEVEL;
    end

    // Output code selection
    always_comb begin
        unique case (mark)
            MARK_RISE: dac_next = raw_sq ? {PREFIX_UPPER, rnd_q}
                                         : {PREFIX_LOWER, rnd_q};
            MARK_FALL: dac_next = raw_sq ? {PREFIX_UPPER, rnd_q}
                                         : {PREFIX_LOWER, rnd_q};
            default:   dac_next = raw_sq ? '1 : '0;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)
            dac_code <= '0;
        else if (!en)
            dac_code <= '0;
        else
            dac_code <= dac_next;
    end

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (dac_code == '0)); // R12
    AST_LEVEL_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick_q != rise_tick && tick_q != fall_tick)
        |=> (dac_code == '1 || dac_code == '0)); // R4
    AST_MARK_MIDLEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (tick_q == rise_tick || tick_q == fall_tick))
        |=> (dac_code[DAC_W-1 -: 3] == PREFIX_UPPER ||
             dac_code[DAC_W-1 -: 3] == PREFIX_LOWER)); // R5
    AST_COINCIDE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rise_tick == fall_tick && tick_q == rise_tick && !raw_sq)
        |=> (dac_code[DAC_W-1 -: 3] == PREFIX_LOWER)); // R9

endmodule

// File: tb/sqdither_gen_test.sv
module sqdither_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] ftw = '0;
    logic [15:0] rise_tick = '0;
    logic [15:0] fall_tick = '0;
    logic [13:0] dac_code;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic [31:0] m_acc;
    logic [15:0] m_tick;
    logic [10:0] m_rnd;
    logic [13:0] m_dac;
    string       m_tag;

    always #2.5 clk = ~clk;

    sqdither_gen uut (
        .clk(clk), .rst_n(rst_n), .en(en), .ftw(ftw),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .dac_code(dac_code)
    );

    typedef struct packed {
        logic [31:0] ftw;
        logic [15:0] rise;
        logic [15:0] fall;
        logic        en;
        logic [15:0] cycles;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h40000000, 16'd1,  16'd3,  1'b1, 16'd40},   // period 4: R6 R8
        '{32'h03D70A3D, 16'd33, 16'd65, 1'b1, 16'd400},  // 3 MHz at 200 MHz
        '{32'h55555555, 16'd2,  16'd2,  1'b1, 16'd30},   // coincident marks R9
        '{32'h00000000, 16'd5,  16'd9,  1'b1, 16'd20},   // no wrap
        '{32'h40000000, 16'd1,  16'd3,  1'b0, 16'd10},   // disabled R12
        '{32'hFFFFFFFF, 16'd0,  16'd1,  1'b1, 16'd20},   // wrap almost every clock
        '{32'h0CCCCCCD, 16'd10, 16'd0,  1'b1, 16'd200}
    };

    function automatic logic [10:0] rnd_step(logic [10:0] q);
        return {q[9:0], q[10] ^ q[8]};
    endfunction

    // Compute the next model state from the inputs held before the edge
    task automatic model_edge();
        logic [32:0] s;
        if (!rst_n) begin
            m_acc = '0; m_tick = '0; m_rnd = 11'h001; m_dac = '0; m_tag = "R1";
        end else begin
            if (!en) begin
                m_dac = '0; m_tag = "R12";
            end else if (m_tick == rise_tick) begin
                m_dac = m_acc[31] ? {3'b101, m_rnd} : {3'b010, m_rnd};
                m_tag = (rise_tick == fall_tick) ? "R9" : (m_acc[31] ? "R5" : "R6");
            end else if (m_tick == fall_tick) begin
                m_dac = m_acc[31] ? {3'b101, m_rnd} : {3'b010, m_rnd};
                m_tag = m_acc[31] ? "R8" : "R7";
            end else begin
                m_dac = m_acc[31] ? 14'h3FFF : 14'h0000;
                m_tag = "R4";
            end
            if (en) begin
                s = {1'b0, m_acc} + {1'b0, ftw};
                m_acc  = s[31:0];
                m_tick = s[32] ? 16'd0 : m_tick + 16'd1;
            end
            m_rnd = rnd_step(m_rnd);
        end
    endtask

    task automatic check(string tag, logic [13:0] exp);
        n_chk++;
        if (dac_code !== exp) begin
            n_bad++;
            $display("FAIL %s: dac_code=%h expected=%h at %0t", tag, dac_code, exp, $time);
        end
    endtask

    // One clock: model, edge, sample at negedge, compare with model
    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check({m_tag, "/R2/R3/R10/R11"}, m_dac);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    localparam logic [13:0] HAND [8] = '{14'h0000, 14'h1002, 14'h3FFF, 14'h2808,
                                         14'h0000, 14'h1020, 14'h3FFF, 14'h2880};

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b1;
        ftw = 32'h40000000; rise_tick = 16'd1; fall_tick = 16'd3;
        step(); step();
        check("R1 reset output", 14'h0000);

        // Hand-computed sequence after release: R2 R6 R8 R10 R11
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            step();
            check($sformatf("R11 hand edge %0d (R2 R6 R8 R10)", k + 1), HAND[k]);
        end

        // Table walk
        for (int v = 0; v < NV; v++) begin
            ftw = VECS[v].ftw;
            rise_tick = VECS[v].rise;
            fall_tick = VECS[v].fall;
            en = VECS[v].en;
            for (int c = 0; c < int'(VECS[v].cycles); c++) step();
        end

        // Resume after a disabled stretch: phase and ticks held (R12)
        en = 1'b0;
        ftw = 32'h40000000; rise_tick = 16'd1; fall_tick = 16'd3;
        repeat (5) step();
        en = 1'b1;
        repeat (12) step();

        // Mid-run reset re-seeds everything (R1)
        rst_n = 1'b0;
        step();
        check("R1 mid-run reset", 14'h0000);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            step();
            check($sformatf("R1 reseed edge %0d (R10)", k + 1), HAND[k]);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule